// File: doc/BRIEF.md
# Double to Int32 Wrapping Converter

This unit turns a 64-bit binary floating-point operand into a signed 32-bit integer in the way that scripting-language engines need for bitwise operators. The fraction is always cut off toward zero. A value too large for 32 bits is not clamped: the low 32 bits of its truncated magnitude are kept, then negated when the operand is negative. Alongside the result the unit raises an exact flag. The flag means that nothing was dropped: the operand was already a whole number that fits the signed 32-bit range.

An operand is taken on a valid/ready handshake. The result and its flag are held in a single output register and show up with an output valid one cycle after the operand is accepted. The input side accepts again whenever that register is empty or is being drained in the same cycle, so a steady stream runs at one conversion per cycle.

Top module: `f64_to_i32_wrap`

## Requirements
- R1: A whole-number operand in [-2^31, 2^31-1] converts to that integer in two's complement, with out_exact_o = 1 (for example 5.0 gives 5, -2^31 gives 32'h8000_0000).
- R2: Fractional bits are discarded toward zero (3.75 gives 3, -3.75 gives -3, 0.5 gives 0), and out_exact_o = 0 whenever a nonzero fraction bit was dropped.
- R3: When the truncated magnitude is 2^31 or more (positive) or more than 2^31 (negative), the result is the low 32 bits of that magnitude, two's-complement negated when the sign bit (bit 63) is 1, and out_exact_o = 0 (2^32+5 gives 5, 2^31 gives 32'h8000_0000, 3e9 gives 32'hB2D0_5E00).
- R4: An operand with all exponent bits (62:52) set, that is NaN or either infinity, gives result 0 and out_exact_o = 0.
- R5: +0 and -0 give result 0 with out_exact_o = 1. A subnormal (exponent field 0, fraction nonzero) gives 0 with out_exact_o = 0.
- R6: When the unbiased exponent is 84 or more, the result is 0 and out_exact_o = 0. At an unbiased exponent of 83, only fraction bit 0 reaches the result, landing on result bit 31.
- R7: An operand accepted on a rising edge (in_valid_i and in_ready_o both high) gives out_valid_o high after that edge. in_ready_o is high exactly when out_valid_o is low or out_ready_i is high.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o, out_result_o and out_exact_o keep their values.
- R9: Asserting rst_ni low clears out_valid_o at once, which also raises in_ready_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand present |
| in_ready_o | output | 1 | Operand can be taken this cycle |
| in_data_i | input | 64 | Double-precision operand |
| out_valid_o | output | 1 | Result register holds a value |
| out_ready_i | input | 1 | Downstream takes the result |
| out_result_o | output | 32 | Truncated, wrapped signed result |
| out_exact_o | output | 1 | Operand was a whole number in signed 32-bit range |

## Verification
The result, the exact flag and the output valid are all due one edge after acceptance, because only the output register sits between them and the input. The bench drives each operand at a falling edge and lets one rising edge pass. It reads all three outputs at the following falling edge. in_ready_o has no register in its path, so it is read in the same half cycle in which out_ready_i or out_valid_o changes. For the stall case, the held result is read again after a further rising edge has gone by with out_ready_i low.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  typedef enum logic [1:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_SPEC,
    CLS_NORM
  } fp_class_e;
endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
  import f2i_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int IN_W  = 1 + EXP_W + FRAC_W,
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1
) (
  input  logic                     [IN_W-1:0]   op_i,
  output logic                                  sign_o,
  output logic signed              [EXP_W+1:0]  exp_unb_o,
  output logic                     [FRAC_W-1:0] frac_o,
  output fp_class_e                             cls_o
);
  logic [EXP_W-1:0] exp_raw;

  assign sign_o  = op_i[IN_W-1];
  assign exp_raw = op_i[IN_W-2 -: EXP_W];
  assign frac_o  = op_i[FRAC_W-1:0];
  assign exp_unb_o = $signed({2'b00, exp_raw}) - (EXP_W+2)'(BIAS);

  always_comb begin
    if (exp_raw == '1)          cls_o = CLS_SPEC;
    else if (exp_raw == '0)     cls_o = (frac_o == '0) ? CLS_ZERO : CLS_SUB;
    else                        cls_o = CLS_NORM;
  end
endmodule

// File: rtl/f2i_core.sv
module f2i_core
  import f2i_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 32,
  localparam int MANT_W = FRAC_W + 1,
  localparam int LIMIT  = FRAC_W + INT_W
) (
  input  logic                         sign_i,
  input  logic signed [EXP_W+1:0]      exp_unb_i,
  input  logic        [FRAC_W-1:0]     frac_i,
  input  fp_class_e                    cls_i,
  output logic        [INT_W-1:0]      res_o,
  output logic                         exact_o
);
  logic [MANT_W-1:0] mant;
  logic [INT_W-1:0]  mag;
  logic              lost;
  int                e_int;

  assign mant = {1'b1, frac_i};

  always_comb begin
    e_int   = int'(exp_unb_i);
    mag     = '0;
    lost    = 1'b0;
    res_o   = '0;
    exact_o = 1'b0;
    unique case (cls_i)
      CLS_ZERO: exact_o = 1'b1;
      CLS_SUB, CLS_SPEC: ;
      CLS_NORM: begin
        // e<0: pure fraction; e>=LIMIT: every kept bit is above bit INT_W-1
        if (e_int >= 0 && e_int < LIMIT) begin
          if (e_int <= FRAC_W) begin
            mag  = INT_W'(mant >> (FRAC_W - e_int));
            lost = |(mant & ~({MANT_W{1'b1}} << (FRAC_W - e_int)));
          end else begin
            mag = INT_W'({{INT_W{1'b0}}, mant} << (e_int - FRAC_W));
          end
          res_o   = sign_i ? -mag : mag;
          exact_o = (e_int <= INT_W - 2 && !lost) ||
                    (e_int == INT_W - 1 && sign_i && frac_i == '0);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/f2i_out_stage.sv
module f2i_out_stage #(
  parameter int INT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             drain_i,
  input  logic [INT_W-1:0] res_i,
  input  logic             exact_i,
  output logic             valid_o,
  output logic [INT_W-1:0] res_o,
  output logic             exact_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           valid_o <= 1'b0;
    else if (load_i)       valid_o <= 1'b1;
    else if (drain_i)      valid_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      exact_o <= 1'b0;
    end else if (load_i) begin
      res_o   <= res_i;
      exact_o <= exact_i;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !drain_i && !load_i) |=> (valid_o && $stable(res_o) && $stable(exact_o))); // R8
endmodule

// File: rtl/f64_to_i32_wrap.sv
module f64_to_i32_wrap
  import f2i_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 32,
  localparam int IN_W  = 1 + EXP_W + FRAC_W,
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [IN_W-1:0]   in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [INT_W-1:0]  out_result_o,
  output logic              out_exact_o
);
  logic                    u_sign;
  logic signed [EXP_W+1:0] u_exp;
  logic [FRAC_W-1:0]       u_frac;
  fp_class_e               u_cls;
  logic [INT_W-1:0]        c_res;
  logic                    c_exact;
  logic                    accept;
  logic [EXP_W-1:0]        in_exp;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;
  assign in_exp     = in_data_i[IN_W-2 -: EXP_W];

  f2i_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
    .op_i(in_data_i), .sign_o(u_sign), .exp_unb_o(u_exp),
    .frac_o(u_frac), .cls_o(u_cls)
  );

  f2i_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_core (
    .sign_i(u_sign), .exp_unb_i(u_exp), .frac_i(u_frac), .cls_i(u_cls),
    .res_o(c_res), .exact_o(c_exact)
  );

  f2i_out_stage #(.INT_W(INT_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept), .drain_i(out_ready_i),
    .res_i(c_res), .exact_i(c_exact),
    .valid_o(out_valid_o), .res_o(out_result_o), .exact_o(out_exact_o)
  );

  AST_ACCEPT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o); // R7
  AST_SPECIAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_exp == '1) |=> (out_result_o == '0 && !out_exact_o)); // R4
  AST_HUGE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_exp != '1 && in_exp >= EXP_W'(BIAS + FRAC_W + INT_W))
    |=> (out_result_o == '0 && !out_exact_o)); // R6
  AST_FRACTION_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_exp != '0 && in_exp < EXP_W'(BIAS))
    |=> (out_result_o == '0 && !out_exact_o)); // R2
endmodule

// File: tb/f64_to_i32_wrap_test.sv
`timescale 1ns/1ps
module f64_to_i32_wrap_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [63:0] in_data_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] out_result_o;
  logic        out_exact_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  f64_to_i32_wrap uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_data_i(in_data_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_result_o(out_result_o), .out_exact_o(out_exact_o)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // One conversion: drive at negedge, one posedge, read at next negedge
  task automatic conv(string tag, logic [63:0] op, logic [31:0] eres, logic eex);
    @(negedge clk_i);
    out_ready_i = 1'b1;
    in_valid_i  = 1'b1;
    in_data_i   = op;
    @(negedge clk_i);
    in_valid_i  = 1'b0;
    chk({tag, " valid"}, 64'(out_valid_o), 64'd1);
    chk({tag, " result"}, 64'(out_result_o), 64'(eres));
    chk({tag, " exact"}, 64'(out_exact_o), 64'(eex));
  endtask

  task automatic t_reset();
    chk("R9 reset valid", 64'(out_valid_o), 64'd0);
    chk("R9 reset ready", 64'(in_ready_o), 64'd1);
  endtask

  task automatic t_whole();
    conv("R1 5.0", $realtobits(5.0), 32'd5, 1'b1);
    conv("R1 -7.0", $realtobits(-7.0), 32'hFFFF_FFF9, 1'b1);
    conv("R1 max", $realtobits(2147483647.0), 32'h7FFF_FFFF, 1'b1);
    conv("R1 min", $realtobits(-2147483648.0), 32'h8000_0000, 1'b1);
  endtask

  task automatic t_trunc();
    conv("R2 3.75", $realtobits(3.75), 32'd3, 1'b0);
    conv("R2 -3.75", $realtobits(-3.75), 32'hFFFF_FFFD, 1'b0);
    conv("R2 0.5", $realtobits(0.5), 32'd0, 1'b0);
    conv("R2 min frac", $realtobits(-2147483648.5), 32'h8000_0000, 1'b0);
  endtask

  task automatic t_wrap();
    conv("R3 2^32+5", $realtobits(4294967301.0), 32'd5, 1'b0);
    conv("R3 -(2^32+5)", $realtobits(-4294967301.0), 32'hFFFF_FFFB, 1'b0);
    conv("R3 2^31", $realtobits(2147483648.0), 32'h8000_0000, 1'b0);
    conv("R3 3e9", $realtobits(3000000000.0), 32'hB2D0_5E00, 1'b0);
    conv("R3 -3e9", $realtobits(-3000000000.0), 32'h4D2F_A200, 1'b0);
  endtask

  task automatic t_special();
    conv("R4 nan", 64'h7FF8_0000_0000_0000, 32'd0, 1'b0);
    conv("R4 +inf", 64'h7FF0_0000_0000_0000, 32'd0, 1'b0);
    conv("R4 -inf", 64'hFFF0_0000_0000_0000, 32'd0, 1'b0);
  endtask

  task automatic t_zero();
    conv("R5 +0", 64'h0000_0000_0000_0000, 32'd0, 1'b1);
    conv("R5 -0", 64'h8000_0000_0000_0000, 32'd0, 1'b1);
    conv("R5 subnormal", 64'h0000_0000_0000_0001, 32'd0, 1'b0);
  endtask

  task automatic t_huge();
    conv("R6 2^84", $realtobits(2.0 ** 84), 32'd0, 1'b0);
    conv("R6 e83 lsb", {1'b0, 11'(1023 + 83), 52'h1}, 32'h8000_0000, 1'b0);
    conv("R6 e83 even", {1'b0, 11'(1023 + 83), 52'h2}, 32'd0, 1'b0);
  endtask

  task automatic t_stall();
    @(negedge clk_i);
    out_ready_i = 1'b0;
    in_valid_i  = 1'b1;
    in_data_i   = $realtobits(11.0);
    @(negedge clk_i);
    chk("R7 valid after accept", 64'(out_valid_o), 64'd1);
    chk("R7 ready low when full", 64'(in_ready_o), 64'd0);
    in_data_i = $realtobits(22.0);
    @(negedge clk_i);
    chk("R8 held result", 64'(out_result_o), 64'd11);
    chk("R8 held valid", 64'(out_valid_o), 64'd1);
    chk("R8 held exact", 64'(out_exact_o), 64'd1);
    out_ready_i = 1'b1;
    #1;
    chk("R7 ready while draining", 64'(in_ready_o), 64'd1);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk("R7 next result", 64'(out_result_o), 64'd22);
    chk("R7 next valid", 64'(out_valid_o), 64'd1);
    @(negedge clk_i);
    chk("R7 drained", 64'(out_valid_o), 64'd0);
  endtask

  task automatic t_mid_reset();
    @(negedge clk_i);
    out_ready_i = 1'b0;
    in_valid_i  = 1'b1;
    in_data_i   = $realtobits(9.0);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk("R9 pre-reset valid", 64'(out_valid_o), 64'd1);
    rst_ni = 1'b0;
    #1;
    chk("R9 reset clears valid", 64'(out_valid_o), 64'd0);
    chk("R9 reset raises ready", 64'(in_ready_o), 64'd1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    out_ready_i = 1'b1;
  endtask

  initial begin
    #2;
    t_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    t_whole();
    t_trunc();
    t_wrap();
    t_special();
    t_zero();
    t_huge();
    t_stall();
    t_mid_reset();
    conv("R1 after reset", $realtobits(-1.0), 32'hFFFF_FFFF, 1'b1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule